// File: doc/BRIEF.md
# Serial Register Target with Programming-Busy Status

This block is the two-wire serial target end of a small register file that stands in for a device with nonvolatile storage. A controller addresses it with a fixed seven-bit identification pattern in which one bit comes from a board strap input. The controller then either writes one byte to a chosen register or reads back from a chosen register. A read takes the form of an address-setting write, a repeated START and a read-mode identification byte. The register array lives outside the block and is reached through a simple parallel port: a register index, a one-cycle write strobe with its data, and a read-data input that follows the index combinationally.

A write is held inside the block until the controller closes the transfer with STOP. Only then is it committed to the array, and a programming timer starts at the same moment. While the timer runs, the block refuses further data bytes and sets a write-in-progress flag in bit 5 of the control register. Reads stream successive registers for as long as the controller acknowledges, and the index wraps at the top of the array. The lines are open-drain: the block only ever pulls SDA low through an enable output.

Top module: `i2c_nvreg_target`

## Requirements
- R1: The target acknowledges an identification byte only when, MSB first, it reads 0,1,0,1,0, then the level of `addr_sel`, then 0, then the read/write bit (1 = read). Any other byte goes unacknowledged, and the target then leaves SDA alone and accepts nothing until the next START.
- R2: A write is START, identification with read/write bit 0, register index, one data byte and STOP, and the target acknowledges all three bytes. The array write strobe `reg_wr_en` pulses for exactly one cycle, with the index on `reg_addr` and the byte on `reg_wr_data`. It pulses only after the STOP, never at the data-byte acknowledge.
- R3: If a repeated START follows the data byte instead of a STOP, the held write is dropped and the array is not written.
- R4: Every committed write starts a busy period of CLK_HZ/1e6 × BUSY_US clock cycles. While it runs, bit 5 of the byte read from register CTRL_ADDR is 1; once it ends, that bit shows the stored array bit again.
- R5: While the busy period runs, a data byte is not acknowledged and produces no write. Identification and index bytes are still acknowledged.
- R6: A random read (index write, repeated START, identification with read/write bit 1) returns the addressed register's contents, most significant bit first.
- R7: After each byte sent, the register index advances by one and wraps from REG_COUNT-1 to 0, so an acknowledged stream returns consecutive registers.
- R8: A controller NACK after a read byte ends the stream. The target releases SDA and drives nothing on further clocks until the next START.
- R9: A register index of REG_COUNT or above is not acknowledged, and the transfer is then ignored.
- R10: During and right after reset, SDA is released and no array write is issued.
- R11: The target changes its SDA drive only while SCL is low. It pulls SDA low through the acknowledge clock and releases it after that clock's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| addr_sel | input | 1 | Strap bit compared against identification bit 2 |
| reg_addr | output | $clog2(REG_COUNT) | Current register index for reads and writes |
| reg_wr_en | output | 1 | One-cycle array write strobe |
| reg_wr_data | output | 8 | Byte to store on a write strobe |
| reg_rd_data | input | 8 | Array contents at `reg_addr` |

## Verification
The bench builds the block with eight registers, the control register at index 7 and a 200 MHz clock with BUSY_US of 25, which gives a 5000-cycle busy window. That window is short enough to read the control register with the flag set, wait it out and read the flag cleared. It is also long enough to fit a refused second write inside it. With eight registers, a three-byte stream from index 6 crosses the wrap from 7 back to 0. The strap is tied high, so a pattern with that bit cleared checks the strap comparison.

// File: rtl/i2c_nvreg_pkg.sv
package i2c_nvreg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ID,
        ST_ID_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } tgt_state_e;

    localparam logic [4:0] ID_HIGH_BITS = 5'b01010;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl_m;
        logic sda_m;
        logic scl_c;
        logic sda_c;
        logic scl_p;
        logic sda_p;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d       = q;
        d.scl_m = scl_i;
        d.sda_m = sda_i;
        d.scl_c = q.scl_m;
        d.sda_c = q.sda_m;
        d.scl_p = q.scl_c;
        d.sda_p = q.sda_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign sda_s     = q.sda_c;
    assign scl_rise  = q.scl_c & ~q.scl_p;
    assign scl_fall  = ~q.scl_c & q.scl_p;
    assign start_det = q.scl_c & q.scl_p & q.sda_p & ~q.sda_c;
    assign stop_det  = q.scl_c & q.scl_p & ~q.sda_p & q.sda_c;

endmodule

// File: rtl/nv_busy_timer.sv
module nv_busy_timer #(
    parameter int unsigned CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic busy
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (launch)          cnt_d = CW'(CYCLES);
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
        else                 cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != 0);

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_nvreg_pkg::*;
#(
    parameter int REG_COUNT = 8,
    parameter int AW        = $clog2(REG_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          addr_sel,
    input  logic          busy,
    input  logic [7:0]    rd_byte,
    output logic [AW-1:0] ptr,
    output logic [7:0]    wdata,
    output logic          wr_en,
    output logic          sda_oe
);

    localparam logic [8:0]    REG_LIMIT = 9'(REG_COUNT);
    localparam logic [AW-1:0] LAST_IDX  = AW'(REG_COUNT - 1);

    typedef struct packed {
        tgt_state_e    st;
        logic [3:0]    bitcnt;
        logic [7:0]    shreg;
        logic [7:0]    txreg;
        logic [AW-1:0] ptr;
        logic          rw;
        logic [7:0]    wdata;
        logic          pend;
        logic          mack;
        logic          sda_oe;
        logic          wr_en;
    } fsm_t;

    fsm_t q, d;
    logic [6:0] id_expect;

    assign id_expect = {ID_HIGH_BITS, addr_sel, 1'b0};

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (stop_det) begin
            d.wr_en  = q.pend;
            d.pend   = 1'b0;
            d.st     = ST_IDLE;
            d.sda_oe = 1'b0;
        end else if (start_det) begin
            d.st     = ST_ID;
            d.bitcnt = '0;
            d.pend   = 1'b0;
            d.sda_oe = 1'b0;
        end else begin
            unique case (q.st)
                ST_ID, ST_ADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        d.shreg  = {q.shreg[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                    end else if (scl_fall && q.bitcnt == 4'd8) begin
                        d.st = ST_SKIP;
                        if (q.st == ST_ID) begin
                            if (q.shreg[7:1] == id_expect) begin
                                d.sda_oe = 1'b1;
                                d.rw     = q.shreg[0];
                                d.st     = ST_ID_ACK;
                            end
                        end else if (q.st == ST_ADDR) begin
                            if ({1'b0, q.shreg} < REG_LIMIT) begin
                                d.sda_oe = 1'b1;
                                d.ptr    = q.shreg[AW-1:0];
                                d.st     = ST_ADDR_ACK;
                            end
                        end else if (!busy) begin
                            d.sda_oe = 1'b1;
                            d.wdata  = q.shreg;
                            d.pend   = 1'b1;
                            d.st     = ST_WDATA_ACK;
                        end
                    end
                end
                ST_ID_ACK: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (q.rw) begin
                            d.st     = ST_TX;
                            d.txreg  = rd_byte;
                            d.sda_oe = ~rd_byte[7];
                        end else begin
                            d.st     = ST_ADDR;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.st     = ST_WDATA;
                        d.bitcnt = '0;
                        d.sda_oe = 1'b0;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        d.st     = ST_SKIP;
                        d.sda_oe = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd7) begin
                            d.sda_oe = 1'b0;
                            d.st     = ST_TX_ACK;
                            d.ptr    = (q.ptr == LAST_IDX) ? '0 : q.ptr + 1'b1;
                        end else begin
                            d.txreg  = {q.txreg[6:0], 1'b0};
                            d.sda_oe = ~q.txreg[6];
                            d.bitcnt = q.bitcnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.st     = ST_TX;
                            d.bitcnt = '0;
                            d.txreg  = rd_byte;
                            d.sda_oe = ~rd_byte[7];
                        end else begin
                            d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign ptr    = q.ptr;
    assign wdata  = q.wdata;
    assign wr_en  = q.wr_en;
    assign sda_oe = q.sda_oe;

endmodule

// File: rtl/i2c_nvreg_target.sv
module i2c_nvreg_target #(
    parameter int REG_COUNT = 8,
    parameter int CTRL_ADDR = REG_COUNT - 1,
    parameter int CLK_HZ    = 100_000_000,
    parameter int BUSY_US   = 20_000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         sda_oe,
    input  logic                         addr_sel,
    output logic [$clog2(REG_COUNT)-1:0] reg_addr,
    output logic                         reg_wr_en,
    output logic [7:0]                   reg_wr_data,
    input  logic [7:0]                   reg_rd_data
);

    localparam int            AW          = $clog2(REG_COUNT);
    localparam int            BUSY_CYCLES = (CLK_HZ / 1_000_000) * BUSY_US;
    localparam logic [AW-1:0] CTRL_IDX    = AW'(CTRL_ADDR);

    logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic       wip;
    logic [7:0] rd_byte;

    i2c_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    always_comb begin
        rd_byte = reg_rd_data;
        if (reg_addr == CTRL_IDX) rd_byte[5] = wip;
    end

    i2c_target_fsm #(
        .REG_COUNT (REG_COUNT),
        .AW        (AW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_sel  (addr_sel),
        .busy      (wip),
        .rd_byte   (rd_byte),
        .ptr       (reg_addr),
        .wdata     (reg_wr_data),
        .wr_en     (reg_wr_en),
        .sda_oe    (sda_oe)
    );

    nv_busy_timer #(
        .CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (reg_wr_en),
        .busy   (wip)
    );

endmodule

// File: rtl/i2c_nvreg_chk.sv
module i2c_nvreg_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic wip
);

    // R2: the array strobe lasts a single cycle
    assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R4: a committed write is followed by the busy window
    assert_busy_after_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> wip);

    // R5: nothing reaches the array while programming is under way
    assert_no_write_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> !reg_wr_en);

    // R11: the drive only moves while the clock line is low
    assert_drive_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

endmodule

bind i2c_nvreg_target i2c_nvreg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .wip       (wip)
);

// File: tb/tb_i2c_nvreg_target.sv
module tb_i2c_nvreg_target;

    localparam int NREG = 8;
    localparam int CTRL = 7;
    localparam int BUSY = 5000;
    localparam int Q    = 10;
    localparam logic [7:0] ID_W = 8'h54;
    localparam logic [7:0] ID_R = 8'h55;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic       reg_wr_en;
    logic [2:0] reg_addr;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;
    logic [7:0] mem [NREG];
    logic [7:0] model [NREG];

    item_t exp_q[$];
    int    obs_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    wr_seen = 0;

    always #2.5 clk = ~clk;

    assign sda_line    = ~(m_low | sda_oe);
    assign reg_rd_data = mem[reg_addr];

    i2c_nvreg_target #(
        .REG_COUNT (NREG),
        .CTRL_ADDR (CTRL),
        .CLK_HZ    (200_000_000),
        .BUSY_US   (25)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .addr_sel    (1'b1),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(i * 29 + 5);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= init_val(i);
        end else if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
        end
    end

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: collect array writes, then pair observations with expectations
    always @(negedge clk) begin
        if (rst_n && reg_wr_en) begin
            wr_seen++;
            obs_q.push_back(32'h1000 | ({29'd0, reg_addr} << 8) | {24'd0, reg_wr_data});
        end
        while (obs_q.size() > 0) begin
            int o;
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                check("unexpected", o, -1);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(e.tag, o, e.val);
            end
        end
    end

    task automatic expect_item(string tag, int val);
        item_t e;
        e.tag = tag;
        e.val = val;
        exp_q.push_back(e);
    endtask

    task automatic expect_write(string tag, int a, logic [7:0] v);
        expect_item(tag, 32'h1000 | (a << 8) | int'(v));
        model[a] = v;
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic send_bit(logic b);
        m_low = ~b; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        obs_q.push_back(sda_line ? 0 : 1);
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic rd_byte(logic ack);
        logic [7:0] v;
        v = '0;
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            v = {v[6:0], sda_line};
            tick(Q);
            scl = 1'b0;
        end
        send_bit(~ack);
        obs_q.push_back(int'(v));
    endtask

    task automatic random_read(string tag, int a, int n);
        expect_item(tag, 1); expect_item(tag, 1); expect_item(tag, 1);
        bus_start(); wr_byte(ID_W); wr_byte(8'(a));
        bus_start(); wr_byte(ID_R);
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1);
        end
    endtask

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = init_val(i);
        tick(5);
        // R10: reset state
        check("R10 sda_oe in reset", int'(sda_oe), 0);
        check("R10 wr_en in reset", int'(reg_wr_en), 0);
        rst_n = 1'b1;
        tick(20);
        check("R10 sda_oe after reset", int'(sda_oe), 0);

        // R1: strap bit mismatch, then bus ignored until START
        expect_item("R1 id mismatch nack", 0);
        expect_item("R1 ignored byte", 0);
        bus_start(); wr_byte(8'h50); wr_byte(8'h02); bus_stop();
        tick(20);

        // R2: byte write committed only at STOP
        expect_item("R2 id ack", 1);
        expect_item("R2 addr ack", 1);
        expect_item("R2 data ack", 1);
        bus_start(); wr_byte(ID_W); wr_byte(8'h02); wr_byte(8'hA5);
        tick(50);
        check("R2 no write before stop", wr_seen, 0);
        check("R11 released after ack", int'(sda_oe), 0);
        expect_write("R2 commit", 2, 8'hA5);
        bus_stop();
        tick(5);

        // R5: second write inside busy window
        expect_item("R5 id ack", 1);
        expect_item("R5 addr ack", 1);
        expect_item("R5 data nack", 0);
        bus_start(); wr_byte(ID_W); wr_byte(8'h03); wr_byte(8'h11); bus_stop();
        tick(5);

        // R4: flag set while busy
        random_read("R4 setup", CTRL, 0);
        expect_item("R4 wip set", int'(model[CTRL] | 8'h20));
        rd_byte(1'b0); bus_stop();
        tick(BUSY);
        random_read("R4 setup", CTRL, 0);
        expect_item("R4 wip clear", int'(model[CTRL]));
        rd_byte(1'b0); bus_stop();
        tick(10);

        // R6: random read of written and untouched registers
        random_read("R6 setup", 2, 0);
        expect_item("R6 read written", int'(model[2]));
        rd_byte(1'b0); bus_stop();
        random_read("R6 setup", 3, 0);
        expect_item("R6 read untouched", int'(model[3]));
        rd_byte(1'b0); bus_stop();

        // R7: stream across the wrap
        random_read("R7 setup", 6, 0);
        expect_item("R7 first", int'(model[6]));
        expect_item("R7 second", int'(model[7]));
        expect_item("R7 wrapped", int'(model[0]));
        rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b0);

        // R8: after NACK, target stays off the line
        tick(5);
        check("R8 released after nack", int'(sda_oe), 0);
        expect_item("R8 no drive", 8'hFF);
        rd_byte(1'b0); bus_stop();

        // R9: index out of range
        expect_item("R9 id ack", 1);
        expect_item("R9 addr nack", 0);
        bus_start(); wr_byte(ID_W); wr_byte(8'(NREG)); bus_stop();

        // R3: repeated START drops the held write
        expect_item("R3 id ack", 1);
        expect_item("R3 addr ack", 1);
        expect_item("R3 data ack", 1);
        expect_item("R3 reread id ack", 1);
        expect_item("R3 unchanged", int'(model[4]));
        bus_start(); wr_byte(ID_W); wr_byte(8'h04); wr_byte(8'h77);
        bus_start(); wr_byte(ID_R); rd_byte(1'b0); bus_stop();
        tick(50);
        check("R3 no write", wr_seen, 1);

        tick(20);
        check("queue expected drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule